// File: doc/BRIEF.md
# Block-Lock Write Protection Controller

This block sits between a serial memory's command decoder and its nonvolatile array. It rules on every write request. A request carries a 13-bit array address, or a flag that selects the protection status register, plus one data byte. The block combines three inputs to decide whether an array write may proceed: a volatile write-enable latch, a two-bit field that protects the top share of the array, and an external protect pin. An array write that is refused is dropped without a trace. The bus transfer around it still completes, but the array is left unchanged.

The status register is where the bus layer routes a write aimed at the highest address, FFFFh; that route shows up here as the select flag. A write to the register is read as one of three commands. Two fixed codes set or clear the enable latch. Any byte with bit 6 set is a program command, which loads the block-protect field and the protect-enable bit. Once protect-enable is set and the pin is driven high, the field and the enable bit are frozen. The latch can still be toggled, so writes to unprotected parts of the array keep working.

Top module: `wpc_guard`

## Requirements
- R1: After a synchronous active-low reset the status register reads 00h and no array write is allowed.
- R2: While the enable latch (status bit 1) is clear, `arr_wr_ok` stays low for every address.
- R3: A register write of exactly 02h sets the enable latch and a register write of exactly 00h clears it. Either change is visible on `prot_reg` in the cycle after the request, and neither needs any precondition, not even when the register is locked.
- R4: A register write with data bit 6 set is a program command. If the latch is set and the register is unlocked, it copies data bits 4:3 into the block-protect field (status bits 4:3) and data bit 7 into protect-enable (status bit 7) one cycle later. Status bits 0, 2, 5 and 6 always read zero.
- R5: A program command issued while the latch is clear leaves the register unchanged.
- R6: The block-protect field blocks array writes over an address range. Code 00 blocks nothing, 01 blocks 1800h–1FFFh, 10 blocks 1000h–1FFFh and 11 blocks 0000h–1FFFh. Outside the blocked range, a write with the latch set is allowed.
- R7: `reg_locked` is high exactly when protect-enable is set and `wp_pin` is high. While it is high, program commands leave the field and protect-enable unchanged.
- R8: With `wp_pin` low the register is never locked, so a program command can clear protect-enable.
- R9: `arr_wr_ok` is asserted only for a valid request with `req_reg` low. Register requests never allow an array write.
- R10: A register write with bit 6 clear whose value is neither 00h nor 02h leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A write request is present this cycle |
| req_reg | input | 1 | Request targets the status register, not the array |
| req_addr | input | 13 | Array byte address |
| req_data | input | 8 | Write data byte |
| wp_pin | input | 1 | External write-protect pin, high = protect |
| arr_wr_ok | output | 1 | Current array write request may be committed |
| prot_reg | output | 8 | Status register read value |
| reg_locked | output | 1 | Status register frozen by pin and protect-enable |

## Verification
The hardest state to reach is the hardware lock, because it can only be entered by a fixed order of steps. The latch must be set while the pin is low, then protect-enable is programmed, and only then is the pin raised. The stimulus walks exactly that path. While locked, it tries to program new values, toggles the latch, and probes the array on both sides of the one-quarter boundary. It then drops the pin and shows that protect-enable can be cleared again.

// File: rtl/wpc_pkg.sv
// Package: shared bit positions and command codes of the protection status register.
// Assumes an 8-bit register; positions are fixed because the bus layer decodes them.
package wpc_pkg;
    localparam int REG_W     = 8;
    localparam int WEL_BIT   = 1;
    localparam int BP_LO     = 3;
    localparam int BP_HI     = 4;
    localparam int PROG_BIT  = 6;
    localparam int PE_BIT    = 7;
    localparam logic [REG_W-1:0] CODE_LATCH_SET = 8'h02;
    localparam logic [REG_W-1:0] CODE_LATCH_CLR = 8'h00;
endpackage

// File: rtl/wpc_range_dec.sv
// Module: wpc_range_dec
// Maps the two-bit block-protect code to a protected top share of the array
// (none, quarter, half, all) and flags whether an address falls inside it.
// Assumes ADDR_W >= 2 so that a quarter of the array is a whole number of bytes.
module wpc_range_dec #(
    parameter int ADDR_W = 13
) (
    input  logic [1:0]        bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              prot_o
);
    localparam int SPAN_W = ADDR_W + 1;
    localparam logic [SPAN_W-1:0] DEPTH = SPAN_W'(1) << ADDR_W;
    localparam logic [SPAN_W-1:0] QTR   = DEPTH >> 2;

    logic [SPAN_W-1:0] floor_q [4];

    // Lowest protected address per code; code 3 covers four quarters.
    for (genvar g = 0; g < 4; g++) begin : g_floor
        localparam int SHARE = (g == 3) ? 4 : g;
        assign floor_q[g] = DEPTH - SPAN_W'(SHARE) * QTR;
    end

    // Address is protected when at or above the selected floor.
    assign prot_o = ({1'b0, addr_i} >= floor_q[bp_i]);
endmodule

// File: rtl/wpc_status_reg.sv
// Module: wpc_status_reg
// Holds the enable latch, block-protect field and protect-enable bit, and
// interprets register writes as latch-set, latch-clear or program commands.
// Assumes at most one register write per cycle, presented on wr_en_i.
module wpc_status_reg
    import wpc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] data_i,
    input  logic             wp_pin_i,
    output logic             wel_o,
    output logic [1:0]       bp_o,
    output logic             pe_o,
    output logic             locked_o
);
    logic is_prog;
    logic prog_ok;

    // Register is frozen only when the pin backs up protect-enable.
    assign locked_o = pe_o & wp_pin_i;
    assign is_prog  = data_i[PROG_BIT];
    assign prog_ok  = wel_o & ~locked_o;

    // Apply one command per register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_o <= 1'b0;
            bp_o  <= 2'b00;
            pe_o  <= 1'b0;
        end else if (wr_en_i) begin
            if (is_prog) begin
                if (prog_ok) begin
                    bp_o <= data_i[BP_HI:BP_LO];
                    pe_o <= data_i[PE_BIT];
                end
            end else if (data_i == CODE_LATCH_SET) begin
                wel_o <= 1'b1;
            end else if (data_i == CODE_LATCH_CLR) begin
                wel_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wpc_guard.sv
// Module: wpc_guard (top)
// Decides whether an array write may be committed and owns the protection
// status register. Assumes the bus layer turns an access to the highest
// address into req_reg and drops array writes when arr_wr_ok is low.
module wpc_guard
    import wpc_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_reg,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [REG_W-1:0]  req_data,
    input  logic              wp_pin,
    output logic              arr_wr_ok,
    output logic [REG_W-1:0]  prot_reg,
    output logic              reg_locked
);
    logic       wel;
    logic [1:0] bp;
    logic       pe;
    logic       in_prot;

    wpc_status_reg u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (req_valid & req_reg),
        .data_i   (req_data),
        .wp_pin_i (wp_pin),
        .wel_o    (wel),
        .bp_o     (bp),
        .pe_o     (pe),
        .locked_o (reg_locked)
    );

    wpc_range_dec #(.ADDR_W(ADDR_W)) u_range (
        .bp_i   (bp),
        .addr_i (req_addr),
        .prot_o (in_prot)
    );

    // Array write allowed only with the latch set and outside the blocked share.
    assign arr_wr_ok = req_valid & ~req_reg & wel & ~in_prot;

    // Assemble the read view; unused positions read zero.
    always_comb begin
        prot_reg                = '0;
        prot_reg[WEL_BIT]       = wel;
        prot_reg[BP_HI:BP_LO]   = bp;
        prot_reg[PE_BIT]        = pe;
    end
endmodule

// File: rtl/wpc_guard_chk.sv
// Module: wpc_guard_chk
// Property checker for wpc_guard, attached by bind; observes top ports only.
module wpc_guard_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_reg,
    input logic [ADDR_W-1:0] req_addr,
    input logic              wp_pin,
    input logic              arr_wr_ok,
    input logic [7:0]        prot_reg,
    input logic              reg_locked
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> prot_reg == 8'h00); // R1
    AST_NO_WRITE_WITHOUT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_reg[1] |-> !arr_wr_ok); // R2
    AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_reg & 8'h65) == 8'h00); // R4
    AST_ALL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        prot_reg[4:3] == 2'b11 |-> !arr_wr_ok); // R6
    AST_QUARTER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_reg[4:3] == 2'b01 && req_addr[ADDR_W-1 -: 2] == 2'b11) |-> !arr_wr_ok); // R6
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_locked |=> $stable(prot_reg[7]) && $stable(prot_reg[4:3])); // R7
    AST_PIN_LOW_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_pin |-> !reg_locked); // R8
    AST_REG_NOT_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        req_reg |-> !arr_wr_ok); // R9
endmodule

bind wpc_guard wpc_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_reg    (req_reg),
    .req_addr   (req_addr),
    .wp_pin     (wp_pin),
    .arr_wr_ok  (arr_wr_ok),
    .prot_reg   (prot_reg),
    .reg_locked (reg_locked)
);

// File: tb/wpc_guard_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps every address under every protect code and walks the lock sequence.
module wpc_guard_tb_top;
    localparam int AW    = 13;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_reg = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          wp_pin = 1'b0;
    logic          arr_wr_ok;
    logic [7:0]    prot_reg;
    logic          reg_locked;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    wpc_guard #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_reg(req_reg),
        .req_addr(req_addr), .req_data(req_data), .wp_pin(wp_pin),
        .arr_wr_ok(arr_wr_ok), .prot_reg(prot_reg), .reg_locked(reg_locked)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One register write; result is visible at the following negedge.
    task automatic reg_wr(input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_reg = 1'b1; req_data = d;
        @(negedge clk);
        req_valid = 1'b0; req_reg = 1'b0; req_data = '0;
    endtask

    // Sweep all array addresses; expected allow computed from quarters blocked.
    task automatic sweep(input string req, input int quarters, input bit latch);
        int floor_a = DEPTH - quarters * (DEPTH / 4);
        req_valid = 1'b1; req_reg = 1'b0;
        for (int a = 0; a < DEPTH; a++) begin
            req_addr = AW'(a);
            #1;
            chk(req, int'(arr_wr_ok), int'(latch && a < floor_a));
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", prot_reg, 8'h00);
        req_valid = 1'b1; req_addr = '0; #1;
        chk("R1", arr_wr_ok, 0);
        req_valid = 1'b0;
        sweep("R2", 0, 1'b0);
        reg_wr(8'hD8);
        chk("R5", prot_reg, 8'h00);
        reg_wr(8'h03);
        chk("R10", prot_reg, 8'h00);
        reg_wr(8'h02);
        chk("R3", prot_reg, 8'h02);
        reg_wr(8'h81);
        chk("R10", prot_reg, 8'h02);
        for (int b = 0; b < 4; b++) begin
            reg_wr(8'h40 | 8'(b << 3));
            chk("R4", prot_reg, 8'h02 | (b << 3));
            sweep("R6", (b == 3) ? 4 : b, 1'b1);
        end
        reg_wr(8'hFF);
        chk("R4", prot_reg, 8'h9A);
        chk("R8", reg_locked, 0);
        reg_wr(8'h40);
        chk("R8", prot_reg, 8'h02);
        // Lock sequence: program protect-enable with pin low, then raise the pin.
        reg_wr(8'hC8);
        chk("R4", prot_reg, 8'h8A);
        wp_pin = 1'b1; #1;
        chk("R7", reg_locked, 1);
        reg_wr(8'h58);
        chk("R7", prot_reg, 8'h8A);
        reg_wr(8'h00);
        chk("R3", prot_reg, 8'h88);
        reg_wr(8'h02);
        chk("R3", prot_reg, 8'h8A);
        req_valid = 1'b1; req_addr = 13'h1800; #1;
        chk("R6", arr_wr_ok, 0);
        req_addr = 13'h17FF; #1;
        chk("R6", arr_wr_ok, 1);
        req_reg = 1'b1; req_data = 8'h01; req_addr = '0; #1;
        chk("R9", arr_wr_ok, 0);
        req_valid = 1'b0; req_reg = 1'b0; req_data = '0;
        wp_pin = 1'b0; #1;
        chk("R8", reg_locked, 0);
        reg_wr(8'h40);
        chk("R8", prot_reg, 8'h02);
        reg_wr(8'h00);
        chk("R3", prot_reg, 8'h00);
        sweep("R2", 0, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule